// File: doc/BRIEF.md
# Program Counter and Return Stack Unit

This block keeps the 16-bit program counter and the return-stack pointer of a small byte-oriented interpreter CPU. Once per operation the surrounding core presents a decoded operation code, a 12-bit address operand, the contents of the two named registers, the contents of register zero and an immediate byte, and strobes `start`. The unit then works out the next program counter value. It handles plain and indexed jumps, conditional skips, system-call targets, subroutine calls and subroutine returns.

Calls and returns keep their return addresses in external byte-wide memory. The unit reaches it through a single synchronous port with one cycle of read latency. The stack grows downward and the stack pointer always addresses the next free slot. Each saved address takes two bytes, with the high byte at the lower address. Every finished operation produces a one-cycle `done` pulse. An operation that cannot be executed also raises `err` in that same cycle and leaves the unit's state unchanged.

Top module: `pc_stack_unit`

## Requirements
- R1: During reset and after it, `pc` reads 0x0200, `sp` reads the parameter STACK_TOP (default 0x0EFE), and both `done` and `err` are low.
- R2: Operation code 0 (jump) sets `pc` to the address operand extended with zeros. The new `pc` and a `done` pulse appear one clock edge after `start` is sampled.
- R3: Operation code 1 (indexed jump) sets `pc` to the address operand plus the unsigned value of `v0`, computed in 16 bits with no masking to 12 bits. For example, 0xFFF + 0xFF gives 0x10FE.
- R4: Operation codes 4 (skip if `vx` equals `imm`) and 5 (skip if they differ) add 2 to `pc` when their condition holds and otherwise leave `pc` unchanged. The result and `done` are due after one edge.
- R5: Operation codes 6 (skip if `vx` equals `vy`) and 7 (skip if they differ) add 2 to `pc` when their condition holds and otherwise leave `pc` unchanged. The result and `done` are due after one edge.
- R6: Operation code 2 (call) writes the old `pc` high byte to address `sp` and then its low byte to `sp`+1, on two consecutive cycles. It then sets `pc` to the zero-extended operand and lowers `sp` by 2. The `done` pulse comes three edges after `start` is sampled.
- R7: Operation code 3 (return) reads the high byte from `sp`+2 and the low byte from `sp`+3, loads them into `pc`, and raises `sp` by 2. The `done` pulse comes four edges after `start` is sampled.
- R8: Operation code 8 (system call) with an operand on the allowed list (default 0x0E0, 0x0EE) gives a `done` pulse with `err` low and no change to `pc`. A system call with any other operand, and any code from 9 to 15, gives `done` and `err` together, with `pc` and `sp` unchanged.
- R9: A `start` that arrives while a call or return is in progress is ignored: it produces no extra `done` and does not alter `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin the presented operation |
| op | input | 4 | Decoded operation code |
| addr_opnd | input | 12 | Address operand |
| vx | input | 8 | Value of the first named register |
| vy | input | 8 | Value of the second named register |
| v0 | input | 8 | Value of register zero |
| imm | input | 8 | Immediate byte |
| mem_rdata | input | 8 | Stack memory read data, one cycle after the address |
| mem_addr | output | 16 | Stack memory byte address |
| mem_we | output | 1 | Stack memory write enable |
| mem_wdata | output | 8 | Stack memory write data |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal-operation flag, valid with `done` |

## Verification
Jumps, skips and system calls are due one edge after `start` is sampled. Calls are due after three edges and returns after four, because the return needs two address phases plus the read latency. The driver records the cycle count at which it raises `start` and pushes each expected item together with the cycle in which it is due. The monitor samples on falling edges and compares the cycle of each `done` against that due cycle, in addition to `pc`, `sp` and `err`, so an early or late result fails just as a wrong value does. The stored byte order of calls is checked in the bench's memory model after each call has finished.

// File: rtl/pcsu_pkg.sv
// Package: operation codes and stack sequencer states shared by the
// program-counter unit. Assumes a 4-bit decoded operation field.
package pcsu_pkg;
    typedef enum logic [3:0] {
        OP_JMP   = 4'd0,
        OP_JMPX  = 4'd1,
        OP_CALL  = 4'd2,
        OP_RET   = 4'd3,
        OP_SEQI  = 4'd4,
        OP_SNEI  = 4'd5,
        OP_SEQR  = 4'd6,
        OP_SNER  = 4'd7,
        OP_SYS   = 4'd8
    } pcsu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CALL_HI, ST_CALL_LO, ST_RET_HI, ST_RET_LO, ST_RET_FIN
    } pcsu_stk_e;
endpackage

// File: rtl/pcsu_next_pc.sv
// Module: combinational next-PC evaluator for every single-cycle operation.
// Assumes PC is two bytes wide; flags calls/returns so the sequencer takes them.
module pcsu_next_pc #(
    parameter int PW       = 16,
    parameter int OW       = 12,
    parameter int N_SYS    = 2,
    parameter logic [N_SYS*OW-1:0] SYS_LIST = {12'h0EE, 12'h0E0}
) (
    input  logic [3:0]    op,
    input  logic [OW-1:0] addr_opnd,
    input  logic [7:0]    vx,
    input  logic [7:0]    vy,
    input  logic [7:0]    v0,
    input  logic [7:0]    imm,
    input  logic [PW-1:0] pc_cur,
    output logic [PW-1:0] pc_nxt,
    output logic          illegal,
    output logic          is_call,
    output logic          is_ret
);
    import pcsu_pkg::*;

    localparam logic [PW-1:0] STEP = PW'(2);

    logic [N_SYS-1:0] sys_hit;
    logic [PW-1:0]    opnd_ext;

    assign opnd_ext = PW'(addr_opnd);

    // One comparator per entry of the allowed system-call list.
    for (genvar g = 0; g < N_SYS; g++) begin : g_sys
        assign sys_hit[g] = (addr_opnd == SYS_LIST[g*OW +: OW]);
    end

    // Select the next PC and classify the operation.
    always_comb begin
        pc_nxt  = pc_cur;
        illegal = 1'b0;
        is_call = 1'b0;
        is_ret  = 1'b0;
        case (op)
            OP_JMP:  pc_nxt = opnd_ext;
            OP_JMPX: pc_nxt = opnd_ext + PW'(v0);
            OP_CALL: is_call = 1'b1;
            OP_RET:  is_ret  = 1'b1;
            OP_SEQI: if (vx == imm) pc_nxt = pc_cur + STEP;
            OP_SNEI: if (vx != imm) pc_nxt = pc_cur + STEP;
            OP_SEQR: if (vx == vy)  pc_nxt = pc_cur + STEP;
            OP_SNER: if (vx != vy)  pc_nxt = pc_cur + STEP;
            OP_SYS:  illegal = ~|sys_hit;
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/pcsu_stack_seq.sv
// Module: return-stack sequencer. Owns the stack pointer and drives a
// byte-wide synchronous memory (read data one cycle after the address).
// Saved PCs are big-endian; the stack grows downward, SP at the next free slot.
module pcsu_stack_seq #(
    parameter int          AW        = 16,
    parameter int          PW        = 16,
    parameter logic [AW-1:0] STACK_TOP = 16'h0EFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_call,
    input  logic          go_ret,
    input  logic [PW-1:0] tgt,
    input  logic [PW-1:0] pc_cur,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          fin,
    output logic [PW-1:0] pc_new,
    output logic [AW-1:0] sp_out,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata
);
    import pcsu_pkg::*;

    localparam logic [AW-1:0] SLOT = AW'(2);

    pcsu_stk_e     st;
    logic [AW-1:0] sp_q;
    logic [PW-1:0] tgt_q;
    logic [7:0]    hi_q;

    // State, stack pointer, call target and fetched high byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            sp_q  <= STACK_TOP;
            tgt_q <= '0;
            hi_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (go_call) begin
                        tgt_q <= tgt;
                        st    <= ST_CALL_HI;
                    end else if (go_ret) begin
                        st <= ST_RET_HI;
                    end
                end
                ST_CALL_HI: st <= ST_CALL_LO;
                ST_CALL_LO: begin
                    sp_q <= sp_q - SLOT;
                    st   <= ST_IDLE;
                end
                ST_RET_HI: st <= ST_RET_LO;
                ST_RET_LO: begin
                    hi_q <= mem_rdata;
                    st   <= ST_RET_FIN;
                end
                ST_RET_FIN: begin
                    sp_q <= sp_q + SLOT;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Memory port: address, write strobe and byte to store per state.
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = sp_q;
        mem_wdata = pc_cur[7:0];
        case (st)
            ST_CALL_HI: begin
                mem_we    = 1'b1;
                mem_wdata = pc_cur[15:8];
            end
            ST_CALL_LO: begin
                mem_we   = 1'b1;
                mem_addr = sp_q + AW'(1);
            end
            ST_RET_HI: mem_addr = sp_q + AW'(2);
            ST_RET_LO: mem_addr = sp_q + AW'(3);
            default: ;
        endcase
    end

    // Completion and the PC value handed back to the top level.
    assign busy   = (st != ST_IDLE);
    assign fin    = (st == ST_CALL_LO) || (st == ST_RET_FIN);
    assign pc_new = (st == ST_RET_FIN) ? {hi_q, mem_rdata} : tgt_q;
    assign sp_out = sp_q;

    // R6: a call lowers SP by exactly one slot when it completes.
    a_r6_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CALL_LO) |=> (sp_q == $past(sp_q) - SLOT));
    // R7: a return raises SP by exactly one slot when it completes.
    a_r7_sp_up: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RET_FIN) |=> (sp_q == $past(sp_q) + SLOT));
    // R6: the write burst is two bytes at consecutive addresses.
    a_r6_two_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> (mem_we && mem_addr == $past(mem_addr) + AW'(1)));
endmodule

// File: rtl/pc_stack_unit.sv
// Module: top of the program-counter unit. Holds the PC register, runs
// single-cycle operations directly and hands calls/returns to the sequencer.
// Assumes start is ignored while the sequencer is busy.
module pc_stack_unit #(
    parameter int            AW        = 16,
    parameter int            OW        = 12,
    parameter int            N_SYS     = 2,
    parameter logic [N_SYS*OW-1:0] SYS_LIST = {12'h0EE, 12'h0E0},
    parameter logic [AW-1:0] STACK_TOP = 16'h0EFE,
    parameter logic [15:0]   PC_RESET  = 16'h0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic [OW-1:0] addr_opnd,
    input  logic [7:0]    vx,
    input  logic [7:0]    vy,
    input  logic [7:0]    v0,
    input  logic [7:0]    imm,
    input  logic [7:0]    mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    output logic [15:0]   pc,
    output logic [AW-1:0] sp,
    output logic          done,
    output logic          err
);
    localparam int PW = 16;

    logic [PW-1:0] pc_q, pc_nxt, pc_seq;
    logic          illegal, is_call, is_ret;
    logic          busy, fin, accept;
    logic          done_q, err_q;

    pcsu_next_pc #(.PW(PW), .OW(OW), .N_SYS(N_SYS), .SYS_LIST(SYS_LIST)) u_next (
        .op(op), .addr_opnd(addr_opnd), .vx(vx), .vy(vy), .v0(v0), .imm(imm),
        .pc_cur(pc_q), .pc_nxt(pc_nxt), .illegal(illegal),
        .is_call(is_call), .is_ret(is_ret)
    );

    assign accept = start && !busy;

    pcsu_stack_seq #(.AW(AW), .PW(PW), .STACK_TOP(STACK_TOP)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .go_call(accept && is_call), .go_ret(accept && is_ret),
        .tgt(PW'(addr_opnd)), .pc_cur(pc_q), .mem_rdata(mem_rdata),
        .busy(busy), .fin(fin), .pc_new(pc_seq), .sp_out(sp),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    // PC register plus the registered done/err pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= PC_RESET;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (fin) begin
                pc_q   <= pc_seq;
                done_q <= 1'b1;
            end else if (accept && !is_call && !is_ret) begin
                if (!illegal) pc_q <= pc_nxt;
                done_q <= 1'b1;
                err_q  <= illegal;
            end
        end
    end

    assign pc   = pc_q;
    assign done = done_q;
    assign err  = err_q;

    // R8: a rejected operation leaves PC and SP as they were.
    a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(pc) && $stable(sp)));
    // R8: err is only ever reported together with done.
    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R9: while the sequencer is busy a new start writes no memory change of PC.
    a_r9_busy_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable(pc));
endmodule

// File: tb/pc_stack_unit_bench.sv
// Scoreboard bench: the driver pushes expected results with their due cycle,
// the monitor pops and compares them whenever done is seen.
module pc_stack_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [11:0] addr_opnd = '0;
    logic [7:0]  vx = '0, vy = '0, v0 = '0, imm = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [15:0] pc, sp;
    logic        done, err;

    always #2.5 clk = ~clk;

    pc_stack_unit u_pc_stack_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr_opnd(addr_opnd),
        .vx(vx), .vy(vy), .v0(v0), .imm(imm), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .pc(pc), .sp(sp), .done(done), .err(err)
    );

    // Byte memory model, synchronous read, aliased on the low address byte.
    logic [7:0] bmem [0:255];
    always_ff @(posedge clk) begin
        if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= bmem[mem_addr[7:0]];
    end

    typedef struct {
        logic [15:0] pc;
        logic [15:0] sp;
        logic        err;
        int          due;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] stk[$];
    logic [15:0] m_pc, m_sp;
    int cyc = 0, checks = 0, errors = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare every completion against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 32'(pc), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.due, {e.tag, " due cycle"}, 32'(cyc), 32'(e.due));
                chk(pc == e.pc,   {e.tag, " pc"}, 32'(pc), 32'(e.pc));
                chk(sp == e.sp,   {e.tag, " sp"}, 32'(sp), 32'(e.sp));
                chk(err == e.err, {e.tag, " err"}, 32'(err), 32'(e.err));
            end
        end
    end

    // Driver: predict the result, queue it, pulse start, let it finish.
    task automatic run_op(input logic [3:0] o, input logic [11:0] a,
                          input logic [7:0] x, input logic [7:0] y,
                          input logic [7:0] z, input logic [7:0] i,
                          input string tag, input bit poke_busy);
        exp_t e;
        int   lat = 1;
        logic bad = 1'b0;
        case (o)
            4'd0: m_pc = {4'h0, a};
            4'd1: m_pc = {4'h0, a} + {8'h00, z};
            4'd2: begin stk.push_back(m_pc); m_pc = {4'h0, a}; m_sp = m_sp - 16'd2; lat = 3; end
            4'd3: begin m_pc = stk.pop_back(); m_sp = m_sp + 16'd2; lat = 4; end
            4'd4: if (x == i) m_pc = m_pc + 16'd2;
            4'd5: if (x != i) m_pc = m_pc + 16'd2;
            4'd6: if (x == y) m_pc = m_pc + 16'd2;
            4'd7: if (x != y) m_pc = m_pc + 16'd2;
            4'd8: bad = !(a == 12'h0E0 || a == 12'h0EE);
            default: bad = 1'b1;
        endcase
        e.pc = m_pc; e.sp = m_sp; e.err = bad; e.due = cyc + lat; e.tag = tag;
        sb.push_back(e);
        start = 1'b1; op = o; addr_opnd = a; vx = x; vy = y; v0 = z; imm = i;
        @(negedge clk);
        if (poke_busy) begin
            op = 4'd0; addr_opnd = 12'h123;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                // R1: reset values
                chk(pc == 16'h0200, "R1 pc", 32'(pc), 32'h0200);
                chk(sp == 16'h0EFE, "R1 sp", 32'(sp), 32'h0EFE);
                chk(done == 1'b0,   "R1 done", 32'(done), 0);
                chk(err == 1'b0,    "R1 err", 32'(err), 0);
                rst_n = 1'b1;
                m_pc = 16'h0200; m_sp = 16'h0EFE;
                @(negedge clk);
                run_op(4'd0, 12'h345, 8'h00, 8'h00, 8'h00, 8'h00, "R2 jump", 1'b0);
                run_op(4'd1, 12'hFFF, 8'h00, 8'h00, 8'hFF, 8'h00, "R3 indexed max", 1'b0);
                run_op(4'd1, 12'h300, 8'h00, 8'h00, 8'h00, 8'h00, "R3 indexed zero", 1'b0);
                run_op(4'd4, 12'h000, 8'h5A, 8'h00, 8'h00, 8'h5A, "R4 eq-imm taken", 1'b0);
                run_op(4'd4, 12'h000, 8'h5A, 8'h00, 8'h00, 8'h5B, "R4 eq-imm not taken", 1'b0);
                run_op(4'd5, 12'h000, 8'h01, 8'h00, 8'h00, 8'h80, "R4 ne-imm taken", 1'b0);
                run_op(4'd5, 12'h000, 8'hC3, 8'h00, 8'h00, 8'hC3, "R4 ne-imm not taken", 1'b0);
                run_op(4'd6, 12'h000, 8'h77, 8'h77, 8'h00, 8'h00, "R5 eq-reg taken", 1'b0);
                run_op(4'd6, 12'h000, 8'h77, 8'h76, 8'h00, 8'h00, "R5 eq-reg not taken", 1'b0);
                run_op(4'd7, 12'h000, 8'h00, 8'hFF, 8'h00, 8'h00, "R5 ne-reg taken", 1'b0);
                run_op(4'd7, 12'h000, 8'h10, 8'h10, 8'h00, 8'h00, "R5 ne-reg not taken", 1'b0);
                run_op(4'd0, 12'hABC, 8'h00, 8'h00, 8'h00, 8'h00, "R2 jump", 1'b0);
                run_op(4'd2, 12'h600, 8'h00, 8'h00, 8'h00, 8'h00, "R6 call", 1'b0);
                // R6: big-endian bytes of old PC 0x0ABC at 0x..FE/0x..FF
                chk(bmem[8'hFE] == 8'h0A, "R6 high byte", 32'(bmem[8'hFE]), 32'h0A);
                chk(bmem[8'hFF] == 8'hBC, "R6 low byte",  32'(bmem[8'hFF]), 32'hBC);
                run_op(4'd4, 12'h000, 8'h01, 8'h00, 8'h00, 8'h01, "R4 skip in callee", 1'b0);
                run_op(4'd2, 12'h7F0, 8'h00, 8'h00, 8'h00, 8'h00, "R6 nested call", 1'b0);
                chk(bmem[8'hFC] == 8'h06, "R6 nested high", 32'(bmem[8'hFC]), 32'h06);
                chk(bmem[8'hFD] == 8'h02, "R6 nested low",  32'(bmem[8'hFD]), 32'h02);
                run_op(4'd3, 12'h000, 8'h00, 8'h00, 8'h00, 8'h00, "R7 return inner", 1'b0);
                run_op(4'd3, 12'h000, 8'h00, 8'h00, 8'h00, 8'h00, "R7 return outer", 1'b0);
                run_op(4'd8, 12'h0E0, 8'h00, 8'h00, 8'h00, 8'h00, "R8 sys allowed", 1'b0);
                run_op(4'd8, 12'h200, 8'h00, 8'h00, 8'h00, 8'h00, "R8 sys rejected", 1'b0);
                run_op(4'd15, 12'hFFF, 8'h00, 8'h00, 8'h00, 8'h00, "R8 bad opcode", 1'b0);
                run_op(4'd9, 12'h000, 8'h00, 8'h00, 8'h00, 8'h00, "R8 bad opcode 9", 1'b0);
                run_op(4'd2, 12'h444, 8'h00, 8'h00, 8'h00, 8'h00, "R9 call with start while busy", 1'b1);
                run_op(4'd3, 12'h000, 8'h00, 8'h00, 8'h00, 8'h00, "R9 return with start while busy", 1'b1);
                chk(sb.size() == 0, "R9 scoreboard drained", 32'(sb.size()), 0);
            end
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog expired", 32'(cyc), 0);
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule